// File: doc/BRIEF.md
# Board Status and Control Register File

This block is a 32-bit memory-mapped register window that a processor uses to read board-level status and to ask for a system reset. It decodes only the low 16 bits of the bus address, so the window repeats across any larger region it is mapped into. Most words are read-only. They are assembled from build parameters and from two live inputs: the timer clock frequency in MHz and the installed memory size in GiB.

A read is accepted in one cycle, and its data appears on the registered read port on the next cycle. The data then holds until the next read. Only full 32-bit accesses count. A narrower or wider read returns zero, and a write of any other size is dropped. Writing the soft-reset word with its request bit set produces a one-cycle reset-request pulse. A downstream reset sequencer, which is not part of this block, acts on that pulse. Offsets with no implemented contents read as zero and ignore writes.

Top module: `board_status_regs`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bus_rdata` is zero and `reset_req` is low.
- R2: A read (`bus_sel`=1, `bus_wr`=0) puts its data on `bus_rdata` one clock after it is accepted. `bus_rdata` then holds that value until the next read.
- R3: An access whose `bus_size` (in bytes) is not 4 reads as zero. A write of that kind never raises `reset_req`.
- R4: A 32-bit write to offset 0x10 with data bit 4 set raises `reset_req` for exactly the next cycle. The same write with bit 4 clear raises nothing. A read of offset 0x10 returns zero.
- R5: Offset 0x14 (memory status) reads 0x00000005, which is the locked flag at bit 0 plus the calibrated flag at bit 2.
- R6: Offset 0x30 (clock dividers) reads as follows: bits 7:0 are the clock-0 divide, bits 15:8 are `tmr_mhz`, bits 23:16 are the multiplier, and bits 31:24 are the clock-1 divide. With the default parameters, the two divides and the multiplier are each 1.
- R7: Offset 0x34 (build features) reads 0x0000000E with the default parameters: the three PCIe enables at bits 1, 2 and 3 are set, and the coherence-unit enable at bit 0 is clear.
- R8: Offset 0x38 (memory configuration) reads `ram_gib` in bits 3:0, all ones in bits 15:4, and zero above bit 15.
- R9: The identification words at offsets 0x00, 0x04 and 0x08 read zero. So does every offset with no listed contents, which includes 0x0C, 0x18, 0x1C to 0x2C, 0x3C to 0x48 and unaligned offsets.
- R10: Address bits above bit 15 do not affect decode.
- R11: Writes to any offset other than 0x10 have no effect. A later read of the same word returns the same value as before, and `reset_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; only bits 15:0 are decoded |
| bus_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_mhz | input | 8 | Timer clock frequency in MHz |
| ram_gib | input | 4 | Installed memory size in GiB |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address, a 16-bit decode window, unit divides and multiplier, all three PCIe enables on, and the coherence enable off. With these values the exact feature word and divider constants are known, and the bench can compute them. Live `tmr_mhz` and `ram_gib` values are changed from one access to the next, so each packed field is shown to follow its input rather than a stored copy. Random upper address bits, mixed access sizes and random write data then cover the alias, narrow-access and reset-bit cases on top of directed checks of every listed offset.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int OFS_W = 16;

  // Word offsets inside the 16-bit decode window
  localparam logic [OFS_W-1:0] OFS_SOFT_RST = 16'h0010;
  localparam logic [OFS_W-1:0] OFS_MEM_STAT = 16'h0014;
  localparam logic [OFS_W-1:0] OFS_CLK_DIV  = 16'h0030;
  localparam logic [OFS_W-1:0] OFS_FEATURES = 16'h0034;
  localparam logic [OFS_W-1:0] OFS_MEM_CFG  = 16'h0038;

  // Bit positions the consumers decode
  localparam int RST_REQ_BIT   = 4;
  localparam int MEM_LOCK_BIT  = 0;
  localparam int MEM_CAL_BIT   = 2;
  localparam int FEAT_COH_BIT  = 0;
  localparam int FEAT_PCIE_LSB = 1;
  localparam int MEM_MHZ_LSB   = 4;
  localparam int MEM_MHZ_W     = 12;

  // Only this access size, in bytes, is honoured
  localparam logic [3:0] FULL_WORD_BYTES = 4'd4;
endpackage

// File: rtl/bsr_access_qual.sv
module bsr_access_qual
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic [OFS_W-1:0]  ofs
);
  logic full_word;

  assign full_word = (size == FULL_WORD_BYTES);
  assign rd_ok     = sel && !wr && full_word;
  assign wr_ok     = sel &&  wr && full_word;
  assign ofs       = addr[OFS_W-1:0];

  generate
    if (ADDR_W > OFS_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = &{1'b0, addr[ADDR_W-1:OFS_W]};
    end
  endgenerate
endmodule

// File: rtl/bsr_status_words.sv
module bsr_status_words
  import bsr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MHZ_W     = 8,
  parameter int GIB_W     = 4,
  parameter int NUM_PCIE  = 3,
  parameter logic [NUM_PCIE-1:0] PCIE_EN = '1,
  parameter bit COH_EN    = 1'b0,
  parameter int CLK0_DIV  = 1,
  parameter int CLK1_DIV  = 1,
  parameter int CLK_MUL   = 1
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [MHZ_W-1:0]  mhz,
  input  logic [GIB_W-1:0]  gib,
  output logic [DATA_W-1:0] word
);
  localparam int FLD_W = 8;

  logic [DATA_W-1:0] mem_stat_w, clk_div_w, feat_w, mem_cfg_w;

  always_comb begin
    mem_stat_w = '0;
    mem_stat_w[MEM_LOCK_BIT] = 1'b1;
    mem_stat_w[MEM_CAL_BIT]  = 1'b1;
  end

  always_comb begin
    clk_div_w = '0;
    clk_div_w[FLD_W-1:0]         = FLD_W'(CLK0_DIV);
    clk_div_w[FLD_W +: MHZ_W]    = mhz;
    clk_div_w[2*FLD_W +: FLD_W]  = FLD_W'(CLK_MUL);
    clk_div_w[3*FLD_W +: FLD_W]  = FLD_W'(CLK1_DIV);
  end

  logic [NUM_PCIE-1:0] pcie_bits;
  generate
    for (genvar i = 0; i < NUM_PCIE; i++) begin : g_pcie
      assign pcie_bits[i] = PCIE_EN[i];
    end
  endgenerate

  always_comb begin
    feat_w = '0;
    feat_w[FEAT_COH_BIT] = COH_EN;
    feat_w[FEAT_PCIE_LSB +: NUM_PCIE] = pcie_bits;
  end

  always_comb begin
    mem_cfg_w = '0;
    mem_cfg_w[GIB_W-1:0] = gib;
    mem_cfg_w[MEM_MHZ_LSB +: MEM_MHZ_W] = '1;
  end

  always_comb begin
    unique case (ofs)
      OFS_MEM_STAT: word = mem_stat_w;
      OFS_CLK_DIV:  word = clk_div_w;
      OFS_FEATURES: word = feat_w;
      OFS_MEM_CFG:  word = mem_cfg_w;
      default:      word = '0;
    endcase
  end
endmodule

// File: rtl/bsr_reset_pulse.sv
module bsr_reset_pulse
  import bsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  logic [OFS_W-1:0] ofs,
  input  logic             req_bit,
  output logic             reset_req
);
  always_ff @(posedge clk) begin
    if (rst) reset_req <= 1'b0;
    else     reset_req <= wr_ok && (ofs == OFS_SOFT_RST) && req_bit;
  end

  // R4
  req_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(wr_ok));
endmodule

// File: rtl/board_status_regs.sv
module board_status_regs
  import bsr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int MHZ_W    = 8,
  parameter int GIB_W    = 4,
  parameter int NUM_PCIE = 3,
  parameter logic [NUM_PCIE-1:0] PCIE_EN = '1,
  parameter bit COH_EN   = 1'b0,
  parameter int CLK0_DIV = 1,
  parameter int CLK1_DIV = 1,
  parameter int CLK_MUL  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [MHZ_W-1:0]  tmr_mhz,
  input  logic [GIB_W-1:0]  ram_gib,
  output logic              reset_req
);
  logic              rd_ok, wr_ok;
  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] word;

  bsr_access_qual #(.ADDR_W(ADDR_W)) u_qual (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .size(bus_size),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .ofs(ofs)
  );

  bsr_status_words #(
    .DATA_W(DATA_W), .MHZ_W(MHZ_W), .GIB_W(GIB_W), .NUM_PCIE(NUM_PCIE),
    .PCIE_EN(PCIE_EN), .COH_EN(COH_EN), .CLK0_DIV(CLK0_DIV),
    .CLK1_DIV(CLK1_DIV), .CLK_MUL(CLK_MUL)
  ) u_words (
    .ofs(ofs), .mhz(tmr_mhz), .gib(ram_gib), .word(word)
  );

  bsr_reset_pulse u_rst (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .ofs(ofs),
    .req_bit(bus_wdata[RST_REQ_BIT]), .reset_req(reset_req)
  );

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata};

  // Read data register: a narrow read returns zero, no read holds the value
  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_ok ? word : '0;
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  // R3
  narrow_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_size != 4'd4) |=> (bus_rdata == '0));

  // R3
  narrow_write_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_size != 4'd4) |=> !reset_req);

  // R5
  mem_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && ofs == OFS_MEM_STAT) |=> (bus_rdata == DATA_W'(5)));

  // R11
  no_read_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> !reset_req);
endmodule

// File: tb/sim_board_status_regs.sv
module sim_board_status_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_size = 4'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tmr_mhz = 8'd50;
  logic [3:0]  ram_gib = 4'd1;
  logic        reset_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  board_status_regs u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_mhz(tmr_mhz), .ram_gib(ram_gib),
    .reset_req(reset_req)
  );

  function automatic logic [31:0] exp_rd(logic [31:0] a, logic [3:0] sz,
                                          logic [7:0] mhz, logic [3:0] gib);
    if (sz != 4'd4) return 32'h0;
    case (a[15:0])
      16'h0014: return 32'h0000_0005;
      16'h0030: return {8'd1, 8'd1, mhz, 8'd1};
      16'h0034: return 32'h0000_000E;
      16'h0038: return {16'h0, 12'hFFF, gib};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic exp_req(logic [31:0] a, logic [3:0] sz, logic [31:0] d);
    return (sz == 4'd4) && (a[15:0] == 16'h0010) && d[4];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic [3:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] sz,
                    input logic [31:0] d, output logic rq);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rq = reset_req;
  endtask

  task automatic rd_chk(string req, logic [31:0] a, logic [3:0] sz);
    logic [31:0] d;
    rd(a, sz, d);
    check(req, d, exp_rd(a, sz, tmr_mhz, ram_gib));
  endtask

  initial begin
    logic [31:0] d;
    logic        rq;
    logic [31:0] a;
    logic [3:0]  sz;
    void'($urandom(32'h1234_5eed));

    repeat (3) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    check("R1 reset_req in reset", {31'h0, reset_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 reset_req after reset", {31'h0, reset_req}, 32'h0);

    // Directed reads of each listed word
    rd_chk("R5 mem status", 32'h0000_0014, 4'd4);
    tmr_mhz = 8'd25;
    rd_chk("R6 clock dividers", 32'h0000_0030, 4'd4);
    tmr_mhz = 8'hFF;
    rd_chk("R6 clock dividers max mhz", 32'h0000_0030, 4'd4);
    rd_chk("R7 build features", 32'h0000_0034, 4'd4);
    ram_gib = 4'd2;
    rd_chk("R8 mem config", 32'h0000_0038, 4'd4);
    ram_gib = 4'hF;
    rd_chk("R8 mem config all ones", 32'h0000_0038, 4'd4);
    rd_chk("R9 id 0x00", 32'h0000_0000, 4'd4);
    rd_chk("R9 id 0x04", 32'h0000_0004, 4'd4);
    rd_chk("R9 id 0x08", 32'h0000_0008, 4'd4);
    rd_chk("R9 pcie status 0x18", 32'h0000_0018, 4'd4);
    rd_chk("R9 unaligned 0x15", 32'h0000_0015, 4'd4);
    rd_chk("R4 soft reset reads zero", 32'h0000_0010, 4'd4);
    rd_chk("R10 alias of 0x14", 32'hABCD_0014, 4'd4);
    rd_chk("R3 narrow read 0x14", 32'h0000_0014, 4'd2);
    rd_chk("R3 wide read 0x38", 32'h0000_0038, 4'd8);

    // R2: data holds across idle cycles and writes
    rd(32'h0000_0034, 4'd4, d);
    repeat (3) @(negedge clk);
    check("R2 hold idle", bus_rdata, 32'h0000_000E);
    wr(32'h0000_0038, 4'd4, 32'hFFFF_FFFF, rq);
    check("R2 hold over write", bus_rdata, 32'h0000_000E);
    check("R11 write to RO no req", {31'h0, rq}, 32'h0);
    rd_chk("R11 RO word unchanged", 32'h0000_0038, 4'd4);

    // R4: reset pulse
    wr(32'h0000_0010, 4'd4, 32'h0000_0010, rq);
    check("R4 pulse high", {31'h0, rq}, 32'h1);
    @(negedge clk);
    check("R4 pulse one cycle", {31'h0, reset_req}, 32'h0);
    wr(32'h0000_0010, 4'd4, 32'hFFFF_FFEF, rq);
    check("R4 bit4 clear no req", {31'h0, rq}, 32'h0);
    wr(32'h0000_0010, 4'd1, 32'h0000_0010, rq);
    check("R3 byte write no req", {31'h0, rq}, 32'h0);
    wr(32'h0000_0010, 4'd8, 32'h0000_0010, rq);
    check("R3 dword write no req", {31'h0, rq}, 32'h0);
    wr(32'h5A5A_0010, 4'd4, 32'h0000_0010, rq);
    check("R10 alias reset req", {31'h0, rq}, 32'h1);
    @(negedge clk);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(3))
        0: sz = 4'd1;
        1: sz = 4'd2;
        2: sz = 4'd8;
        default: sz = 4'd4;
      endcase
      if ($urandom_range(3) == 0) sz = 4'd4;
      a = {$urandom_range(16'hFFFF)[15:0], 16'h0};
      if ($urandom_range(7) == 0) a[15:0] = $urandom_range(16'hFFFF)[15:0];
      else                        a[15:0] = 16'(4 * $urandom_range(19));
      tmr_mhz = 8'($urandom_range(255));
      ram_gib = 4'($urandom_range(15));
      if ($urandom_range(1) == 0) begin
        rd(a, sz, d);
        check("R3 R5 R6 R7 R8 R9 R10 random read", d, exp_rd(a, sz, tmr_mhz, ram_gib));
      end else begin
        logic [31:0] wd;
        wd = $urandom;
        wr(a, sz, wd, rq);
        check("R4 R11 random write req", {31'h0, rq}, {31'h0, exp_req(a, sz, wd)});
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule